// File: doc/BRIEF.md
# Ring-Sequenced Load/Store Processor Core

This block is a very small processor core that repeats a fetch, decode and execute loop. All internal data movement goes over one shared 7-bit internal bus. A one-hot ring of step flip-flops selects which single transfer happens in each clock. The core holds these registers:

- a 4-bit program counter
- a memory address register
- a memory buffer register
- an instruction register
- two general registers

Instructions are 7 bits wide. The two top bits [6:5] are the opcode, bit [4] selects a general register, and bits [3:0] give a word address. Opcode 00 copies a memory word into the selected register. Opcode 01 writes the selected register to memory. Opcodes 10 and 11 change nothing.

The core talks to a 16-word memory through a registered port: address, read/write mode, a one-cycle request strobe and a data-out register. The memory answers a read request one clock later through its own data register. The port has fixed timing and no back-pressure. A request is never stalled, and the memory must accept a strobe in the cycle it appears. The general registers, the instruction register, the program counter and the step ring are brought out as plain status outputs.

Top module: `ring_seq_cpu`

## Requirements
- R1: A synchronous reset, `rst` high at a clock edge, clears every register and the memory port outputs, and puts the step ring on step 0 (`step_o` = 1).
- R2: `step_o` always has exactly one bit set. Without a restart it moves up one position per clock and wraps from step 9 to step 0.
- R3: In step 0 the program counter is copied into the memory address register and the counter increments by one, wrapping from 15 to 0.
- R4: In the clock after a step-1 or step-6 edge, `mem_en_o` is high and `mem_addr_o` holds the memory address register. A read result is taken into the buffer register at the end of the second cycle after that, which leaves one idle wait step.
- R5: At the end of step 4 the fetched word is in `ir_o`. Its fields are opcode [6:5], register select [4] and address [3:0].
- R6: Opcode 00 loads the word at the address field into the selected general register at the end of step 9. A load instruction takes 10 cycles.
- R7: Opcode 01 presents the selected register on `mem_wdata_o` with `mem_we_o` = 1 for one strobe cycle, so the word is written at the address field. The ring then returns to step 0 after step 7, so a store takes 8 cycles.
- R8: Opcodes 10 and 11 change no register and no memory word, and the ring returns to step 0 right after step 5. Such an instruction takes 6 cycles.
- R9: At most one source drives the internal bus in any cycle.
- R10: `mem_en_o` is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst | input | 1 | synchronous reset, active high |
| mem_addr_o | output | 4 | memory address register |
| mem_en_o | output | 1 | one-cycle request strobe |
| mem_we_o | output | 1 | mode: 1 write, 0 read |
| mem_wdata_o | output | 7 | data-out register |
| mem_rdata_i | input | 7 | memory data register, valid one cycle after a read strobe |
| pc_o | output | 4 | program counter |
| ir_o | output | 7 | instruction register |
| gpr_o | output | 14 | general registers, register 0 in [6:0] |
| step_o | output | 10 | one-hot step ring |

## Verification
The first results become visible one cycle after the step that produces them:

- A register loaded in step k shows on its output in the cycle of step k+1.
- A request strobe set up in step 1 or 6 is seen by the memory in the following cycle.
- Read data moves into the buffer register two edges after the strobe was set up.

A behavioural model in the bench advances once per rising edge with these same latencies. It also keeps its own copy of memory. All outputs are compared with the model at each falling edge, so every sample is taken after the edge that was expected to change it. Hand-computed memory and register contents are checked after a preloaded program has wrapped the program counter, and again after a mid-run reset.

// File: rtl/rsc_pkg.sv
package rsc_pkg;
  // step positions of the ring
  localparam int ST_F_PC   = 0;
  localparam int ST_F_AR   = 1;
  localparam int ST_F_WAIT = 2;
  localparam int ST_F_DR   = 3;
  localparam int ST_F_IR   = 4;
  localparam int ST_X_ADDR = 5;
  localparam int ST_X_AR   = 6;
  localparam int ST_X_WAIT = 7;
  localparam int ST_X_DR   = 8;
  localparam int ST_X_REG  = 9;
  localparam int NSTEP     = 10;

  // internal bus sources
  localparam int SRC_PC  = 0;
  localparam int SRC_IRA = 1;
  localparam int SRC_MBR = 2;
  localparam int SRC_GPR = 3;
  localparam int NSRC    = 4;

  typedef struct packed {
    logic [NSRC-1:0] src;
    logic ld_mar;
    logic ld_ir;
    logic ld_gpr;
    logic ld_dout;
    logic ld_mbr;
    logic mem_go;
    logic mem_wr;
    logic pc_inc;
    logic restart;
  } uop_t;
endpackage

// File: rtl/ring_sequencer.sv
module ring_sequencer #(
  parameter int N = 10
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         restart,
  output logic [N-1:0] step
);
  localparam logic [N-1:0] FIRST = N'(1);

  always_ff @(posedge clk) begin
    if (rst || restart) step <= FIRST;
    else                step <= {step[N-2:0], step[N-1]};
  end
endmodule

// File: rtl/uop_decode.sv
module uop_decode
  import rsc_pkg::*;
#(
  parameter int OPW = 2
) (
  input  logic [NSTEP-1:0] step,
  input  logic [OPW-1:0]   opcode,
  output uop_t             uop
);
  logic is_load, is_save, is_mem;

  always_comb begin
    is_load = (opcode == OPW'(0));
    is_save = (opcode == OPW'(1));
    is_mem  = is_load || is_save;
    uop     = '0;
    if (step[ST_F_PC]) begin
      uop.src[SRC_PC] = 1'b1;
      uop.ld_mar      = 1'b1;
      uop.pc_inc      = 1'b1;
    end
    if (step[ST_F_AR]) uop.mem_go = 1'b1;
    if (step[ST_F_DR]) uop.ld_mbr = 1'b1;
    if (step[ST_F_IR]) begin
      uop.src[SRC_MBR] = 1'b1;
      uop.ld_ir        = 1'b1;
    end
    if (step[ST_X_ADDR]) begin
      if (is_mem) begin
        uop.src[SRC_IRA] = 1'b1;
        uop.ld_mar       = 1'b1;
      end else begin
        uop.restart = 1'b1;
      end
    end
    if (step[ST_X_AR]) begin
      uop.mem_go = 1'b1;
      uop.mem_wr = is_save;
      if (is_save) begin
        uop.src[SRC_GPR] = 1'b1;
        uop.ld_dout      = 1'b1;
      end
    end
    if (step[ST_X_WAIT] && is_save) uop.restart = 1'b1;
    if (step[ST_X_DR]) uop.ld_mbr = 1'b1;
    if (step[ST_X_REG]) begin
      uop.src[SRC_MBR] = 1'b1;
      uop.ld_gpr       = 1'b1;
    end
  end
endmodule

// File: rtl/or_bus.sv
module or_bus #(
  parameter int NS = 4,
  parameter int W  = 7
) (
  input  logic [NS-1:0]       en,
  input  logic [NS-1:0][W-1:0] src,
  output logic [W-1:0]        bus
);
  logic [NS:0][W-1:0] acc;
  assign acc[0] = '0;
  for (genvar g = 0; g < NS; g++) begin : g_merge
    assign acc[g+1] = acc[g] | (src[g] & {W{en[g]}});
  end
  assign bus = acc[NS];
endmodule

// File: rtl/ring_seq_cpu.sv
module ring_seq_cpu
  import rsc_pkg::*;
#(
  parameter int DW  = 7,
  parameter int AW  = 4,
  parameter int OPW = 2,
  parameter int RSW = 1
) (
  input  logic                      clk,
  input  logic                      rst,
  output logic [AW-1:0]             mem_addr_o,
  output logic                      mem_en_o,
  output logic                      mem_we_o,
  output logic [DW-1:0]             mem_wdata_o,
  input  logic [DW-1:0]             mem_rdata_i,
  output logic [AW-1:0]             pc_o,
  output logic [DW-1:0]             ir_o,
  output logic [(1<<RSW)*DW-1:0]    gpr_o,
  output logic [NSTEP-1:0]          step_o
);
  localparam int NREG = 1 << RSW;
  localparam int IW   = OPW + RSW + AW;
  localparam int PADW = DW - AW;

  logic [AW-1:0]             pc, mar, mem_ar;
  logic [DW-1:0]             mbr, ir, mem_dout, bus;
  logic [NREG-1:0][DW-1:0]   gpr;
  logic                      mem_en, mem_we;
  logic [NSTEP-1:0]          step;
  uop_t                      uop;
  logic [NSRC-1:0][DW-1:0]   srcs;

  logic [OPW-1:0] f_op;
  logic [RSW-1:0] f_sel;
  logic [AW-1:0]  f_addr;

  assign f_op   = ir[IW-1 -: OPW];
  assign f_sel  = ir[AW +: RSW];
  assign f_addr = ir[AW-1:0];

  ring_sequencer #(.N(NSTEP)) u_ring (
    .clk(clk), .rst(rst), .restart(uop.restart), .step(step)
  );

  uop_decode #(.OPW(OPW)) u_dec (
    .step(step), .opcode(f_op), .uop(uop)
  );

  assign srcs[SRC_PC]  = {{PADW{1'b0}}, pc};
  assign srcs[SRC_IRA] = {{PADW{1'b0}}, f_addr};
  assign srcs[SRC_MBR] = mbr;
  assign srcs[SRC_GPR] = gpr[f_sel];

  or_bus #(.NS(NSRC), .W(DW)) u_bus (
    .en(uop.src), .src(srcs), .bus(bus)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pc       <= '0;
      mar      <= '0;
      mbr      <= '0;
      ir       <= '0;
      gpr      <= '0;
      mem_ar   <= '0;
      mem_en   <= 1'b0;
      mem_we   <= 1'b0;
      mem_dout <= '0;
    end else begin
      if (uop.pc_inc)  pc       <= pc + AW'(1);
      if (uop.ld_mar)  mar      <= bus[AW-1:0];
      if (uop.ld_mbr)  mbr      <= mem_rdata_i;
      if (uop.ld_ir)   ir       <= bus;
      if (uop.ld_gpr)  gpr[f_sel] <= bus;
      if (uop.ld_dout) mem_dout <= bus;
      mem_en <= uop.mem_go;
      if (uop.mem_go) begin
        mem_ar <= mar;
        mem_we <= uop.mem_wr;
      end
    end
  end

  assign mem_addr_o  = mem_ar;
  assign mem_en_o    = mem_en;
  assign mem_we_o    = mem_we;
  assign mem_wdata_o = mem_dout;
  assign pc_o        = pc;
  assign ir_o        = ir;
  assign gpr_o       = gpr;
  assign step_o      = step;
endmodule

// File: rtl/ring_seq_cpu_chk.sv
module ring_seq_cpu_chk
  import rsc_pkg::*;
#(
  parameter int DW = 7,
  parameter int AW = 4
) (
  input logic             clk,
  input logic             rst,
  input logic [NSTEP-1:0] step,
  input logic [NSRC-1:0]  src_en,
  input logic [AW-1:0]    pc,
  input logic [DW-1:0]    ir,
  input logic             mem_en,
  input logic             mem_we
);
  a_r2_one_step: assert property (@(posedge clk) disable iff (rst)
    $countones(step) == 1);
  a_r2_advance: assert property (@(posedge clk) disable iff (rst)
    step[ST_F_PC] |=> step[ST_F_AR]);
  a_r9_single_driver: assert property (@(posedge clk) disable iff (rst)
    $onehot0(src_en));
  a_r3_pc_step: assert property (@(posedge clk) disable iff (rst)
    step[ST_F_PC] |=> pc == AW'($past(pc) + AW'(1)));
  a_r10_strobe_pulse: assert property (@(posedge clk) disable iff (rst)
    mem_en |=> !mem_en);
  a_r8_noop_return: assert property (@(posedge clk) disable iff (rst)
    (step[ST_X_ADDR] && ir[DW-1]) |=> step[ST_F_PC]);
  a_r7_write_strobe: assert property (@(posedge clk) disable iff (rst)
    (step[ST_X_AR] && ir[DW-1 -: 2] == 2'b01) |=> (mem_en && mem_we));
  a_r6_load_continues: assert property (@(posedge clk) disable iff (rst)
    (step[ST_X_WAIT] && ir[DW-1 -: 2] == 2'b00) |=> step[ST_X_DR]);
endmodule

bind ring_seq_cpu ring_seq_cpu_chk #(.DW(DW), .AW(AW)) u_chk (
  .clk(clk), .rst(rst), .step(step), .src_en(uop.src), .pc(pc),
  .ir(ir), .mem_en(mem_en), .mem_we(mem_we)
);

// File: tb/ring_seq_cpu_bench.sv
module ring_seq_cpu_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  mem_addr;
  logic        mem_en, mem_we;
  logic [6:0]  mem_wdata, mem_rdata;
  logic [3:0]  pc;
  logic [6:0]  ir;
  logic [13:0] gpr;
  logic [9:0]  step;

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  bit live = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ring_seq_cpu u_ring_seq_cpu (
    .clk(clk), .rst(rst), .mem_addr_o(mem_addr), .mem_en_o(mem_en),
    .mem_we_o(mem_we), .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata),
    .pc_o(pc), .ir_o(ir), .gpr_o(gpr), .step_o(step)
  );

  // behavioural memory seen by the core
  logic [6:0] ram [16];
  logic [6:0] ram_dr = '0;
  assign mem_rdata = ram_dr;
  always @(posedge clk) begin
    if (mem_en) begin
      if (mem_we) ram[mem_addr] <= mem_wdata;
      else        ram_dr <= ram[mem_addr];
    end
  end

  // reference model state
  int         ph;
  logic [3:0] r_pc, r_mar, r_ar;
  logic [6:0] r_mbr, r_ir, r_dout, r_dr;
  logic [6:0] r_gpr [2];
  logic       r_en, r_we;
  logic [6:0] r_mem [16];

  always @(posedge clk) begin
    logic       o_en, o_we;
    logic [3:0] o_ar;
    logic [6:0] o_dout, o_dr;
    logic [1:0] op;
    int         nph;
    if (rst) begin
      ph = 0; r_pc = 0; r_mar = 0; r_ar = 0; r_mbr = 0; r_ir = 0;
      r_dout = 0; r_gpr[0] = 0; r_gpr[1] = 0; r_en = 0; r_we = 0;
    end else begin
      o_en = r_en; o_we = r_we; o_ar = r_ar; o_dout = r_dout; o_dr = r_dr;
      op = r_ir[6:5];
      nph = (ph + 1) % 10;
      r_en = 0;
      case (ph)
        0: begin r_mar = r_pc; r_pc = r_pc + 4'd1; end
        1: begin r_ar = r_mar; r_en = 1; r_we = 0; end
        3: r_mbr = o_dr;
        4: r_ir = r_mbr;
        5: if (op < 2) r_mar = r_ir[3:0]; else nph = 0;
        6: begin
             r_ar = r_mar; r_en = 1; r_we = (op == 1);
             if (op == 1) r_dout = r_gpr[r_ir[4]];
           end
        7: if (op == 1) nph = 0;
        8: r_mbr = o_dr;
        9: r_gpr[r_ir[4]] = r_mbr;
        default: ;
      endcase
      if (o_en) begin
        if (o_we) r_mem[o_ar] = o_dout;
        else      r_dr = r_mem[o_ar];
      end
      ph = nph;
    end
  end

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  // per-cycle comparison with the model
  always @(negedge clk) begin
    if (live && !rst) begin
      check("R2 step ring", 32'(step), 32'(10'(1) << ph));
      check("R3 program counter", 32'(pc), 32'(r_pc));
      check("R5 instruction register", 32'(ir), 32'(r_ir));
      check("R6 general register 0", 32'(gpr[6:0]), 32'(r_gpr[0]));
      check("R6 general register 1", 32'(gpr[13:7]), 32'(r_gpr[1]));
      check("R10 request strobe", 32'(mem_en), 32'(r_en));
      if (r_en) begin
        check("R4 memory address", 32'(mem_addr), 32'(r_ar));
        check("R7 memory mode", 32'(mem_we), 32'(r_we));
        if (r_we) check("R7 write data", 32'(mem_wdata), 32'(r_dout));
      end
    end
  end

  task automatic check_reset_state();
    check("R1 reset step", 32'(step), 32'h1);
    check("R1 reset pc", 32'(pc), 32'h0);
    check("R1 reset ir", 32'(ir), 32'h0);
    check("R1 reset registers", 32'(gpr), 32'h0);
    check("R1 reset strobe", 32'(mem_en), 32'h0);
  endtask

  initial begin
    logic [6:0] prog [16];
    // 0: load r0,12  1: load r1,13  2: save r0,14  3: save r1,15
    // 4,5: no-ops    6: load r0,15  7: save r0,8   8..11: no-ops
    // 12,13: data whose opcodes are no-ops
    prog[0] = 7'h0C; prog[1] = 7'h1D; prog[2] = 7'h2E; prog[3] = 7'h3F;
    prog[4] = 7'h40; prog[5] = 7'h7F; prog[6] = 7'h0F; prog[7] = 7'h28;
    for (int i = 8; i < 12; i++) prog[i] = 7'h40;
    prog[12] = 7'h6B; prog[13] = 7'h52; prog[14] = 7'h00; prog[15] = 7'h00;
    for (int i = 0; i < 16; i++) begin ram[i] = prog[i]; r_mem[i] = prog[i]; end
    r_dr = '0;

    rst = 1;
    repeat (3) @(negedge clk);
    rst = 0;
    check_reset_state();
    live = 1;
    repeat (200) @(negedge clk);
    // mid-run reset (R1)
    rst = 1;
    repeat (2) @(negedge clk);
    rst = 0;
    check_reset_state();
    repeat (400) @(negedge clk);

    // hand-computed results after the program has wrapped
    check("R7 stored word 14", 32'(ram[14]), 32'h6B);
    check("R7 stored word 15", 32'(ram[15]), 32'h52);
    check("R7 stored word 8", 32'(ram[8]), 32'h52);
    check("R6 register 1 loaded", 32'(gpr[13:7]), 32'h52);
    for (int i = 0; i < 8; i++) check("R8 program intact", 32'(ram[i]), 32'(prog[i]));
    for (int i = 9; i < 14; i++) check("R8 no-op leaves memory", 32'(ram[i]), 32'(prog[i]));
    for (int i = 0; i < 16; i++) check("R7 memory vs model", 32'(ram[i]), 32'(r_mem[i]));
    finish_run();
  end

  initial begin
    repeat (5000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule